// File: doc/BRIEF.md
# Return-Address Stack with Level Status

This block is a hardware return-address stack for a DSP program sequencer. Each call pushes a 24-bit return address. Each return pops one. The top entry is always visible on a read port, split into a 16-bit low field and an 8-bit high field, so that a 16-bit datapath can move it in two parts.

Besides empty and full, the block reports a level flag. The level flag is high whenever the occupancy is near either end of the stack.

A sticky error flag records any push onto a full stack and any pop from an empty stack. It also records errors that neighbouring stacks report on a shared input. Only reset clears it.

When enabled, the block raises a one-cycle interrupt request each time a push or pop leaves the stack exactly at the upper warning level. Software can then spill entries before the stack runs out of space.

Top module: `ret_addr_stack`

## Requirements
- R1: A push stores `push_addr_i` on top. A pop removes the top entry, so the entry pushed before it becomes visible again (last in, first out). The top read is zero while the stack is empty. A push or pop becomes visible on the outputs one clock after the edge that samples it.
- R2: `top_lo_o` carries bits 15:0 of the top entry and `top_hi_o` carries bits 23:16.
- R3: `empty_o` is 1 exactly when no entry is held. `full_o` is 1 exactly when all DEPTH entries (33 by default) are held.
- R4: `level_o` is 1 when the occupancy is LO_MARK (3) or less, or HI_MARK (28) or more. It is 0 for any occupancy strictly between them.
- R5: `ovf_o` is set by a push without a pop on a full stack. It is also set by any pop on an empty stack, including a pop that arrives together with a push. Once set, it stays 1 until reset.
- R6: A push on a full stack and a pop on an empty stack leave the stored entries and the occupancy unchanged.
- R7: `ext_ovf_i` high at a clock edge sets `ovf_o`.
- R8: If `irq_en_i` is 1, a push or pop that leaves the occupancy at exactly HI_MARK drives `irq_o` high for exactly one cycle, in the cycle after the operation. With `irq_en_i` at 0, no request is raised. A simultaneous push and pop never raises a request.
- R9: A push and a pop together on a non-empty stack replace the top entry with `push_addr_i` and leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_addr_i | input | 24 | Address to push |
| irq_en_i | input | 1 | Enables the level interrupt request |
| ext_ovf_i | input | 1 | Error report from neighbouring stacks |
| top_lo_o | output | 16 | Low field of the top entry |
| top_hi_o | output | 8 | High field of the top entry |
| empty_o | output | 1 | Stack holds no entry |
| full_o | output | 1 | Stack holds DEPTH entries |
| level_o | output | 1 | Occupancy at or beyond a warning level |
| ovf_o | output | 1 | Sticky overflow/underflow flag |
| irq_o | output | 1 | One-cycle stack interrupt request |

## Verification
The bench builds the block with its default parameters: 33 entries, warning levels at 3 and 28, and 24-bit entries split 16/8. With a depth of 33, the upper warning level can be crossed from both sides before the stack is full. The bench fills the stack entry by entry, checking the level flag on each side of both thresholds. It also raises the interrupt once from a push and once from a pop, and then drives an overflowing push at the full boundary. Separate scenarios cover the underflow and the empty-stack push-with-pop, the top replacement, and the external error input.

// File: rtl/ras_pkg.sv
package ras_pkg;
   // Effective operation after the full/empty guards are applied
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_SWAP = 2'd3
   } ras_op_e;
endpackage

// File: rtl/ras_store.sv
module ras_store
   import ras_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int DEPTH  = 33,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  ras_op_e           op,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] top
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [ADDR_W-1:0] ent [DEPTH];
   logic [IDX_W-1:0]  widx;
   logic [IDX_W-1:0]  ridx;
   logic              we;

   assign ridx = IDX_W'(cnt - CNT_W'(1));
   assign widx = (op == OP_SWAP) ? ridx : IDX_W'(cnt);
   assign we   = (op == OP_PUSH) || (op == OP_SWAP);

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [ADDR_W-1:0] q;
      always_ff @(posedge clk) begin
         if (we && (widx == IDX_W'(i))) q <= wdata;
      end
      assign ent[i] = q;
   end

   assign top = (cnt == '0) ? '0 : ent[ridx];
endmodule

// File: rtl/ras_count.sv
module ras_count
   import ras_pkg::*;
#(
   parameter int DEPTH   = 33,
   parameter int HI_MARK = 28,
   parameter int LO_MARK = 3,
   parameter int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ras_op_e          op,
   output logic [CNT_W-1:0] cnt,
   output logic             empty,
   output logic             full,
   output logic             level
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] HI_C    = CNT_W'(HI_MARK);
   localparam logic [CNT_W-1:0] LO_C    = CNT_W'(LO_MARK);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else begin
         unique case (op)
            OP_PUSH: cnt <= cnt + CNT_W'(1);
            OP_POP:  cnt <= cnt - CNT_W'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign empty = (cnt == '0);
   assign full  = (cnt == DEPTH_C);
   assign level = (cnt <= LO_C) || (cnt >= HI_C);

   // R3
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(empty && full));

   // R6
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= DEPTH_C);

   // R9
   swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SWAP) |=> $stable(cnt));
endmodule

// File: rtl/ras_event.sv
module ras_event
   import ras_pkg::*;
#(
   parameter int DEPTH   = 33,
   parameter int HI_MARK = 28,
   parameter int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  ras_op_e          op,
   input  logic [CNT_W-1:0] cnt,
   input  logic             err,
   input  logic             ext_err,
   input  logic             irq_en,
   output logic             ovf,
   output logic             irq
);
   localparam logic [CNT_W-1:0] HI_C = CNT_W'(HI_MARK);

   logic hit;
   assign hit = ((op == OP_PUSH) && (cnt + CNT_W'(1) == HI_C)) ||
                ((op == OP_POP)  && (cnt - CNT_W'(1) == HI_C));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf <= 1'b0;
         irq <= 1'b0;
      end else begin
         ovf <= ovf | err | ext_err;
         irq <= irq_en & hit;
      end
   end

   // R5
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   // R8
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R8
   irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cnt == HI_C));
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
   import ras_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int LO_W    = 16,
   parameter int DEPTH   = 33,
   parameter int HI_MARK = 28,
   parameter int LO_MARK = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push_i,
   input  logic                 pop_i,
   input  logic [ADDR_W-1:0]    push_addr_i,
   input  logic                 irq_en_i,
   input  logic                 ext_ovf_i,
   output logic [LO_W-1:0]      top_lo_o,
   output logic [ADDR_W-LO_W-1:0] top_hi_o,
   output logic                 empty_o,
   output logic                 full_o,
   output logic                 level_o,
   output logic                 ovf_o,
   output logic                 irq_o
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (LO_W >= ADDR_W) begin : g_bad_split
      $error("LO_W must be narrower than ADDR_W");
   end
   if (LO_MARK >= HI_MARK) begin : g_bad_marks
      $error("LO_MARK must lie below HI_MARK");
   end
   if (HI_MARK >= DEPTH) begin : g_bad_depth
      $error("HI_MARK must lie below DEPTH");
   end

   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] top;
   ras_op_e           op;
   logic              err;

   always_comb begin
      op = OP_IDLE;
      if (push_i && !pop_i && !full_o)     op = OP_PUSH;
      else if (pop_i && !push_i && !empty_o) op = OP_POP;
      else if (pop_i && push_i && !empty_o)  op = OP_SWAP;
   end

   assign err = (push_i && !pop_i && full_o) || (pop_i && empty_o);

   ras_count #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK), .CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .op(op), .cnt(cnt),
      .empty(empty_o), .full(full_o), .level(level_o)
   );

   ras_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk(clk), .op(op), .cnt(cnt), .wdata(push_addr_i), .top(top)
   );

   ras_event #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .CNT_W(CNT_W)) u_event (
      .clk(clk), .rst_n(rst_n), .op(op), .cnt(cnt), .err(err),
      .ext_err(ext_ovf_i), .irq_en(irq_en_i), .ovf(ovf_o), .irq(irq_o)
   );

   assign top_lo_o = top[LO_W-1:0];
   assign top_hi_o = top[ADDR_W-1:LO_W];

   // R6
   full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && full_o) |=> (full_o && ovf_o));

   // R5
   under_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o) |=> (empty_o && ovf_o));

   // R1
   empty_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty_o |-> (top_lo_o == '0 && top_hi_o == '0));
endmodule

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 1'b0;
   logic        pop_i = 1'b0;
   logic [23:0] push_addr_i = '0;
   logic        irq_en_i = 1'b0;
   logic        ext_ovf_i = 1'b0;
   logic [15:0] top_lo_o;
   logic [7:0]  top_hi_o;
   logic        empty_o, full_o, level_o, ovf_o, irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ret_addr_stack u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .push_addr_i(push_addr_i), .irq_en_i(irq_en_i), .ext_ovf_i(ext_ovf_i),
      .top_lo_o(top_lo_o), .top_hi_o(top_hi_o), .empty_o(empty_o),
      .full_o(full_o), .level_o(level_o), .ovf_o(ovf_o), .irq_o(irq_o)
   );

   function automatic logic [23:0] val(int i);
      return 24'hA50000 ^ (24'(i) * 24'h010203);
   endfunction

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
      end
   endtask

   task automatic chk_top(string req, logic [23:0] exp);
      chk(req, "top", {8'h0, top_hi_o, top_lo_o}, {8'h0, exp});
   endtask

   // Applies one request at a negedge; returns at the next negedge,
   // when the result of that edge is visible.
   task automatic step(logic p, logic q, logic [23:0] a);
      push_i = p; pop_i = q; push_addr_i = a;
      @(posedge clk); #1;
      push_i = 1'b0; pop_i = 1'b0; push_addr_i = '0;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; irq_en_i = 1'b0; ext_ovf_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      do_reset();
      @(negedge clk);
      chk("R3", "empty after reset", 32'(empty_o), 1);
      chk("R3", "full after reset", 32'(full_o), 0);
      chk("R4", "level after reset", 32'(level_o), 1);
      chk("R5", "ovf after reset", 32'(ovf_o), 0);
      chk("R8", "irq after reset", 32'(irq_o), 0);
      chk_top("R1", 24'h0);
   endtask

   task automatic t_lifo();
      do_reset();
      step(1, 0, 24'h12_3456);
      chk("R3", "not empty", 32'(empty_o), 0);
      step(1, 0, 24'hAB_CDEF);
      chk_top("R1", 24'hAB_CDEF);
      chk("R2", "low field", 32'(top_lo_o), 32'hCDEF);
      chk("R2", "high field", 32'(top_hi_o), 32'hAB);
      step(1, 0, 24'h00_FFFF);
      step(0, 1, '0);
      chk_top("R1", 24'hAB_CDEF);
      step(0, 1, '0);
      chk_top("R1", 24'h12_3456);
      step(0, 1, '0);
      chk("R1", "empty after last pop", 32'(empty_o), 1);
      chk_top("R1", 24'h0);
      chk("R5", "no spurious ovf", 32'(ovf_o), 0);
   endtask

   task automatic t_fill();
      do_reset();
      irq_en_i = 1'b1;
      for (int n = 1; n <= 33; n++) begin
         step(1, 0, val(n - 1));
         if (n == 3 || n == 4 || n == 27 || n == 28)
            chk("R4", $sformatf("level at %0d", n), 32'(level_o),
                32'((n <= 3) || (n >= 28)));
         if (n == 28) begin
            chk("R8", "irq on push to 28", 32'(irq_o), 1);
            step(0, 0, '0);
            chk("R8", "irq one cycle", 32'(irq_o), 0);
            step(1, 0, val(28));
            chk("R8", "no irq at 29", 32'(irq_o), 0);
            step(0, 1, '0);
            chk("R8", "irq on pop to 28", 32'(irq_o), 1);
         end
         if (n == 32) chk("R3", "not full at 32", 32'(full_o), 0);
      end
      chk("R3", "full at 33", 32'(full_o), 1);
      chk("R5", "no ovf before error", 32'(ovf_o), 0);
      step(1, 0, 24'hDE_AD00);
      chk("R5", "ovf on full push", 32'(ovf_o), 1);
      chk_top("R6", val(32));
      chk("R6", "still full", 32'(full_o), 1);
      step(0, 1, '0);
      chk_top("R6", val(31));
      for (int n = 32; n > 28; n--) step(0, 1, '0);
      chk("R4", "level at 28 after pops", 32'(level_o), 1);
      irq_en_i = 1'b0;
      step(0, 1, '0);
      step(1, 0, 24'h11_1111);
      chk("R8", "irq masked", 32'(irq_o), 0);
      step(1, 1, 24'h22_2222);
      chk("R8", "no irq on replace", 32'(irq_o), 0);
   endtask

   task automatic t_underflow();
      do_reset();
      step(0, 1, '0);
      chk("R5", "ovf on empty pop", 32'(ovf_o), 1);
      chk("R6", "still empty", 32'(empty_o), 1);
      step(0, 0, '0); step(0, 0, '0);
      chk("R5", "ovf sticky", 32'(ovf_o), 1);
      step(1, 0, 24'h5A_5A5A);
      chk_top("R1", 24'h5A_5A5A);
      chk("R5", "ovf sticky after push", 32'(ovf_o), 1);
   endtask

   task automatic t_replace();
      do_reset();
      step(1, 1, 24'h33_3333);
      chk("R5", "ovf on empty push+pop", 32'(ovf_o), 1);
      chk("R6", "empty after empty push+pop", 32'(empty_o), 1);
      do_reset();
      step(1, 0, 24'h01_0001);
      step(1, 0, 24'h02_0002);
      step(1, 1, 24'h03_0003);
      chk_top("R9", 24'h03_0003);
      step(0, 1, '0);
      chk_top("R9", 24'h01_0001);
      step(0, 1, '0);
      chk("R9", "count kept by replace", 32'(empty_o), 1);
      chk("R9", "no ovf from replace", 32'(ovf_o), 0);
   endtask

   task automatic t_external();
      do_reset();
      @(negedge clk);
      chk("R7", "ovf clear before ext", 32'(ovf_o), 0);
      ext_ovf_i = 1'b1;
      @(posedge clk); #1; ext_ovf_i = 1'b0;
      @(negedge clk);
      chk("R7", "ovf from ext", 32'(ovf_o), 1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset_state();
      t_lifo();
      t_fill();
      t_underflow();
      t_replace();
      t_external();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule